// File: doc/BRIEF.md
# Crossbar Receive-Side Arbitration Tree

This block sits in front of one receiver of a full crossbar and decides which of the N source ports reaches it. Each source presents a 4-bit control word, a 32-bit data word and an N-bit destination vector. A source whose vector does not select this receiver (bit `RX_ID`) is treated as idle. The remaining sources compete in a binary tree of 2:1 nodes. The winner's control and data pass straight through to the receiver. The receiver's 2-bit response is steered back to the winning source only.

At each node, an ongoing transfer (TRANS) beats a new request (REQ), and any request beats an idle input. When both children show the same request level, the node's priority bit decides. Each priority bit is a register that the processing elements write through a write-enable, node-index and value port. The selection path is purely combinational. Only the priority bits are state.

Top module: `xbar_arb_tree`

## Requirements
- R1: A source whose destination-vector bit `RX_ID` (bit `i*N+RX_ID` of `src_dst_i`) is 0 never wins, and its response lane stays 00.
- R2: When no unmasked source is requesting, `rx_ctl_o` and `rx_data_o` are 0 and every response lane is 00.
- R3: With exactly one unmasked requester, `rx_ctl_o` and `rx_data_o` equal that source's control and data, whatever its position or the priority bits.
- R4: Request code is `ctl[1:0]`: 0 idle, 1 REQ, 2 TRANS, 3 treated as idle. A TRANS input wins over any REQ input at every node, whatever the priority bits.
- R5: Leaves are padded to a power of two. In 0-based heap order node 0 is the root, node k has children 2k+1 (left, lower source indices) and 2k+2, and source i sits at position NODES+i. When both children show equal non-idle codes, a priority bit of 0 picks the left child and 1 picks the right child.
- R6: The priority bits reset to 0, so after reset source 0 wins among equal requesters.
- R7: On a clock edge with `pri_we_i` high and `pri_idx_i` < NODES, node `pri_idx_i` takes `pri_val_i` and the other bits keep their values. A write with an out-of-range index, or with `pri_we_i` low, changes nothing.
- R8: `rx_rsp_i` appears on `src_rsp_o[2*w+:2]` of the winner w only; all other lanes are 00.
- R9: Code 3 on `ctl[1:0]` is treated as idle and never wins.
- R10: Outputs follow the source inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the priority bits |
| rst_n | input | 1 | Active-low reset |
| src_ctl_i | input | N*4 | Per-source control; [1:0] request code, [3:2] forwarded sideband |
| src_data_i | input | N*32 | Per-source data |
| src_dst_i | input | N*N | Per-source destination vectors |
| src_rsp_o | output | N*2 | Per-source response lanes |
| rx_ctl_o | output | 4 | Control of the winning source |
| rx_data_o | output | 32 | Data of the winning source |
| rx_rsp_i | input | 2 | Response from the receiver |
| pri_we_i | input | 1 | Priority bit write enable |
| pri_idx_i | input | NW | Node index to write |
| pri_val_i | input | 1 | Value written to the priority bit |

## Verification
On every cycle, the assertions check four things. At most one response lane is active. A masked source never gets a response. An idle input set yields zero outputs. Any visible TRANS forces a TRANS output. They also check that a priority bit changes only through an in-range write. Which source actually wins depends on the tree layout and the stored priority bits. Only the bench's directed scenarios can show that: reset order, single requesters at each position, pairings at specific nodes after writes, and rejected out-of-range writes.

// File: rtl/xbar_arb_tree.sv
module xbar_arb_tree #(
  parameter int N     = 7,
  parameter int RX_ID = 0,
  parameter int DW    = 32,
  parameter int CW    = 4,
  parameter int NODES = (1 << $clog2(N)) - 1,
  parameter int NW    = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*CW-1:0] src_ctl_i,
  input  logic [N*DW-1:0] src_data_i,
  input  logic [N*N-1:0]  src_dst_i,
  output logic [N*2-1:0]  src_rsp_o,
  output logic [CW-1:0]   rx_ctl_o,
  output logic [DW-1:0]   rx_data_o,
  input  logic [1:0]      rx_rsp_i,
  input  logic            pri_we_i,
  input  logic [NW-1:0]   pri_idx_i,
  input  logic            pri_val_i
);
  localparam int LEAVES = NODES + 1;
  localparam int TOTAL  = 2 * LEAVES - 1;
  localparam int IW     = (N > 1) ? $clog2(N) : 1;

  function automatic logic [1:0] rank(input logic [1:0] code);
    return (code == 2'd2) ? 2'd2 : (code == 2'd1) ? 2'd1 : 2'd0;
  endfunction

  logic [NODES-1:0] pri_q;
  logic [1:0]       rk [TOTAL];
  logic [IW-1:0]    ix [TOTAL];
  logic [CW-1:0]    ctl_a  [N];
  logic [DW-1:0]    data_a [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pri_q <= '0;
    else if (pri_we_i && pri_idx_i < NW'(NODES)) pri_q[pri_idx_i] <= pri_val_i;
  end

  genvar i, k;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < N) begin : g_real
        assign ctl_a[i]         = src_ctl_i[i*CW +: CW];
        assign data_a[i]        = src_data_i[i*DW +: DW];
        assign rk[NODES+i]      = src_dst_i[i*N + RX_ID] ? rank(ctl_a[i][1:0]) : 2'd0;
        assign ix[NODES+i]      = IW'(i);
      end else begin : g_pad
        assign rk[NODES+i]      = 2'd0;
        assign ix[NODES+i]      = '0;
      end
    end

    for (k = 0; k < NODES; k++) begin : g_node
      logic take_r;
      assign take_r = (rk[2*k+2] > rk[2*k+1]) ||
                      ((rk[2*k+2] == rk[2*k+1]) && (rk[2*k+1] != 2'd0) && pri_q[k]);
      assign rk[k] = take_r ? rk[2*k+2] : rk[2*k+1];
      assign ix[k] = take_r ? ix[2*k+2] : ix[2*k+1];
    end
  endgenerate

  logic          hit;
  logic [IW-1:0] win;
  assign hit = (rk[0] != 2'd0);
  assign win = ix[0];

  assign rx_ctl_o  = hit ? ctl_a[win]  : '0;
  assign rx_data_o = hit ? data_a[win] : '0;

  generate
    for (i = 0; i < N; i++) begin : g_rsp
      assign src_rsp_o[2*i +: 2] = (hit && win == IW'(i)) ? rx_rsp_i : 2'b00;
    end
  endgenerate
endmodule

// File: rtl/xbar_arb_tree_chk.sv
module xbar_arb_tree_chk #(
  parameter int N     = 7,
  parameter int RX_ID = 0,
  parameter int DW    = 32,
  parameter int CW    = 4,
  parameter int NODES = 7,
  parameter int NW    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N*CW-1:0] src_ctl_i,
  input logic [N*N-1:0]  src_dst_i,
  input logic [N*2-1:0]  src_rsp_o,
  input logic [CW-1:0]   rx_ctl_o,
  input logic [DW-1:0]   rx_data_o,
  input logic            pri_we_i,
  input logic [NW-1:0]   pri_idx_i,
  input logic            pri_val_i,
  input logic [NODES-1:0] pri_q
);
  logic [N-1:0] lane_on;
  logic [N-1:0] live;
  logic         any_req, any_trans;

  always_comb begin
    any_req = 1'b0;
    any_trans = 1'b0;
    for (int j = 0; j < N; j++) begin
      lane_on[j] = (src_rsp_o[2*j +: 2] != 2'b00);
      live[j]    = src_dst_i[j*N + RX_ID];
      if (live[j] && src_ctl_i[j*CW +: 2] == 2'd1) any_req = 1'b1;
      if (live[j] && src_ctl_i[j*CW +: 2] == 2'd2) any_trans = 1'b1;
    end
  end

  p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_on));

  p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_on & ~live) == '0);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_req || any_trans) |-> (rx_ctl_o == '0 && rx_data_o == '0 && src_rsp_o == '0));

  p_trans_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_trans |-> rx_ctl_o[1:0] == 2'd2);

  p_req_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !any_trans) |-> rx_ctl_o[1:0] == 2'd1);

  p_pri_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_we_i && pri_idx_i < NW'(NODES)) |=> pri_q[$past(pri_idx_i)] == $past(pri_val_i));

  p_pri_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_we_i && pri_idx_i < NW'(NODES)) |=> $stable(pri_q));
endmodule

bind xbar_arb_tree xbar_arb_tree_chk #(
  .N(N), .RX_ID(RX_ID), .DW(DW), .CW(CW), .NODES(NODES), .NW(NW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .src_ctl_i(src_ctl_i), .src_dst_i(src_dst_i),
  .src_rsp_o(src_rsp_o), .rx_ctl_o(rx_ctl_o), .rx_data_o(rx_data_o),
  .pri_we_i(pri_we_i), .pri_idx_i(pri_idx_i), .pri_val_i(pri_val_i),
  .pri_q(pri_q)
);

// File: tb/xbar_arb_tree_tb_top.sv
module xbar_arb_tree_tb_top;
  localparam int N = 7;
  localparam int RX = 0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N*4-1:0]  src_ctl;
  logic [N*32-1:0] src_data;
  logic [N*N-1:0]  src_dst;
  logic [N*2-1:0]  src_rsp;
  logic [3:0]      rx_ctl;
  logic [31:0]     rx_data;
  logic [1:0]      rx_rsp = 2'b01;
  logic            pri_we = 1'b0;
  logic [2:0]      pri_idx = '0;
  logic            pri_val = 1'b0;

  logic [1:0] code [N];
  logic [N-1:0] dst_on;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int j = 0; j < N; j++) begin
      src_ctl[j*4 +: 4]   = {2'(j), code[j]};
      src_data[j*32 +: 32] = 32'hA500_0000 + 32'(j * 17);
      for (int m = 0; m < N; m++)
        src_dst[j*N + m] = (m == RX) ? dst_on[j] : ~dst_on[j];
    end
  end

  xbar_arb_tree dut_i (
    .clk(clk), .rst_n(rst_n), .src_ctl_i(src_ctl), .src_data_i(src_data),
    .src_dst_i(src_dst), .src_rsp_o(src_rsp), .rx_ctl_o(rx_ctl),
    .rx_data_o(rx_data), .rx_rsp_i(rx_rsp), .pri_we_i(pri_we),
    .pri_idx_i(pri_idx), .pri_val_i(pri_val)
  );

  task automatic clear_all();
    for (int j = 0; j < N; j++) code[j] = 2'd0;
    dst_on = '1;
  endtask

  // expect source w to win (w < 0: nobody)
  task automatic expect_win(input string tag, input int w);
    logic [3:0]  ec;
    logic [31:0] ed;
    logic [N*2-1:0] er;
    #1;
    if (w < 0) begin
      ec = '0; ed = '0; er = '0;
    end else begin
      ec = {2'(w), code[w]};
      ed = 32'hA500_0000 + 32'(w * 17);
      er = (N*2)'(rx_rsp) << (2 * w);
    end
    n_chk++;
    if (rx_ctl !== ec || rx_data !== ed || src_rsp !== er) begin
      n_fail++;
      $display("FAIL %s: ctl=%h data=%h rsp=%h expected ctl=%h data=%h rsp=%h",
               tag, rx_ctl, rx_data, src_rsp, ec, ed, er);
    end
  endtask

  task automatic write_pri(input int idx, input logic v);
    @(negedge clk);
    pri_we = 1'b1; pri_idx = 3'(idx); pri_val = v;
    @(negedge clk);
    pri_we = 1'b0;
  endtask

  task automatic t_reset_order();
    clear_all();
    for (int j = 0; j < N; j++) code[j] = 2'd1;
    expect_win("R6 reset priority all request", 0);
    rx_rsp = 2'b11;
    expect_win("R8 response only to winner", 0);
    rx_rsp = 2'b01;
  endtask

  task automatic t_single();
    for (int j = 0; j < N; j++) begin
      clear_all();
      code[j] = (j % 2 == 0) ? 2'd1 : 2'd2;
      expect_win("R3 single requester R10 same cycle", j);
    end
  endtask

  task automatic t_mask();
    clear_all();
    for (int j = 0; j < N; j++) code[j] = 2'd1;
    dst_on = 7'b1111100;
    expect_win("R1 masked sources 0,1", 2);
    code[0] = 2'd2;
    expect_win("R1 masked TRANS ignored", 2);
    dst_on = '0;
    expect_win("R1 R2 all masked", -1);
  endtask

  task automatic t_idle();
    clear_all();
    expect_win("R2 no requests", -1);
    for (int j = 0; j < N; j++) code[j] = 2'd3;
    expect_win("R9 code 3 everywhere", -1);
    code[6] = 2'd1;
    expect_win("R9 code 3 loses to REQ", 6);
  endtask

  task automatic t_trans();
    clear_all();
    code[0] = 2'd1; code[6] = 2'd2;
    expect_win("R4 TRANS at root", 6);
    clear_all();
    code[0] = 2'd1; code[1] = 2'd2;
    expect_win("R4 TRANS at leaf node", 1);
  endtask

  task automatic t_priority();
    write_pri(3, 1'b1);
    clear_all();
    code[0] = 2'd1; code[1] = 2'd1;
    expect_win("R5 R7 node3 right", 1);
    clear_all();
    code[0] = 2'd2; code[1] = 2'd1;
    expect_win("R4 TRANS beats priority", 0);
    clear_all();
    code[0] = 2'd1; code[4] = 2'd1;
    expect_win("R5 root left default", 0);
    write_pri(0, 1'b1);
    expect_win("R5 R7 root right", 4);
    write_pri(2, 1'b1);
    clear_all();
    code[4] = 2'd1; code[6] = 2'd1;
    expect_win("R5 node2 right", 6);
    write_pri(2, 1'b0);
    expect_win("R7 node2 cleared", 4);
  endtask

  task automatic t_write_bounds();
    write_pri(7, 1'b0);
    clear_all();
    code[0] = 2'd1; code[1] = 2'd1;
    expect_win("R7 out-of-range write ignored", 1);
    @(negedge clk);
    pri_we = 1'b0; pri_idx = 3'd3; pri_val = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_win("R7 no write without enable", 1);
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_order();
    t_single();
    t_mask();
    t_idle();
    t_trans();
    t_priority();
    t_write_bounds();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule